// File: doc/BRIEF.md
# Buffered Serial Transmitter

This block drives one asynchronous serial output line. Software hands it bytes through a single write strobe with an 8-bit data word. Behind that port sit a one-word holding stage and a 10-bit shift register. Each byte leaves as a frame: a low start bit, eight data bits with the least significant bit first, and a high stop bit. Every bit lasts `divisor + 1` clock cycles.

A transmit-enable input gates the whole path. Each time it goes from low to high, the block first sends one idle frame, which is ten bit times of high level, and only then starts on data. A write that finds the shift register idle skips the holding stage and starts a frame on the next cycle. A write that finds a frame in flight is parked in the holding stage. When the stop bit of the running frame ends, the parked byte moves into the shift register, so its start bit follows without a gap.

Two status flags report progress: holding-stage empty and transmission complete. An interrupt request follows the empty flag whenever the interrupt enable is set.

Top module: `uart_tx_hold`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1 and `tx_done` is 1.
- R2: A frame is a start bit at 0, then data bits 0 through 7 in that order, then a stop bit at 1. Every bit holds for exactly `divisor + 1` clock cycles.
- R3: A write (`wr_valid` high at a clock edge) can arrive while `tx_en` is 1, the shift register is idle and no idle frame is due. The start bit then appears on `txd` in the next cycle, and `hold_empty` stays 1.
- R4: A write that arrives while a frame is in flight, or while data is already held, makes `hold_empty` 0 from the next cycle. A second write before the held byte is sent replaces it, and only the last byte is transmitted.
- R5: If a byte is held when a stop bit ends, its start bit begins in the very next cycle. `hold_empty` returns to 1 in that same cycle.
- R6: On a 0-to-1 change of `tx_en`, the line stays 1 for ten bit times (one idle frame) before any held byte is started.
- R7: Whenever `tx_en` is 0 at a clock edge, `txd` is 1 from the next cycle on, and any frame in flight is dropped. Writes made while `tx_en` is 0 are still stored in the holding stage but are not sent.
- R8: `tx_done` becomes 1 when a stop bit ends and nothing else is loaded. It becomes 0 in the cycle after any write.
- R9: `irq` is 1 exactly when `irq_en` is 1 and `hold_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_en | input | 1 | Transmit enable |
| irq_en | input | 1 | Interrupt enable for holding-stage empty |
| divisor | input | 16 | Bit period minus one, in clock cycles |
| wr_valid | input | 1 | Data write strobe, one cycle per byte |
| wr_data | input | 8 | Byte to transmit |
| hold_empty | output | 1 | Holding stage holds no byte |
| tx_done | output | 1 | Last frame finished and nothing pending |
| irq | output | 1 | Interrupt request |
| txd | output | 1 | Serial output line, idle high |

## Verification
The hardest case to reach from the ports is a byte waiting in the holding stage at the moment the idle frame ends. This case must also follow an overwrite. The stimulus gets there by disabling transmission and writing two bytes, so the second replaces the first. It then raises `tx_en` and counts ten bit times of high line before it expects the second byte's start bit. A second stressed point is the back-to-back handoff. The bench writes one byte that bypasses the holding stage and then a second byte while the first is in flight. It samples the last cycle of the stop bit and the next cycle, and expects the new start bit with the empty flag restored.

// File: rtl/uart_tx_pkg.sv
// Shared constants and types for the buffered serial transmitter.
// Assumes 8N1 framing: one start bit, DATA_W data bits, one stop bit.
package uart_tx_pkg;
    localparam int DATA_W  = 8;
    localparam int DIV_W   = 16;
    localparam int FRAME_W = DATA_W + 2;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_BUSY = 1'b1
    } sh_state_t;
endpackage

// File: rtl/uart_baud_gen.sv
// Bit-period timer: pulses tick on the last cycle of each bit period,
// which is divisor+1 cycles long. A restart puts the count back to zero
// so that a newly loaded frame gets a full first bit.
// Assumes divisor is stable while a frame is being sent.
module uart_baud_gen #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = (cnt >= divisor);

    // Count cycles within the current bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_hold_reg.sv
// One-word holding stage. A write stores the word and marks it full.
// A take empties it, unless a write arrives in the same cycle, in which
// case the new word stays held. A write to a full stage overwrites it.
module uart_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data
);
    // Capture written words and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            data <= '0;
        end else if (wr) begin
            full <= 1'b1;
            data <= wr_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/uart_shifter.sv
// Frame shift register. A load fills it with a data frame
// (stop, data, start) or an all-ones idle frame, and each bit tick shifts
// it toward bit 0. Bit 0 drives the line. Vacated positions fill with
// ones, so the line idles high. An abort returns it to idle at once.
module uart_shifter
    import uart_tx_pkg::*;
#(
    parameter int D_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           abort,
    input  logic           bit_tick,
    input  logic           load,
    input  logic           load_idle,
    input  logic [D_W-1:0] load_data,
    output logic           busy,
    output logic           frame_end,
    output logic           txd
);
    localparam int F_W   = D_W + 2;
    localparam int IDX_W = $clog2(F_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(F_W - 1);

    sh_state_t       state;
    logic [F_W-1:0]  sh;
    logic [IDX_W-1:0] idx;

    assign busy      = (state == SH_BUSY);
    assign frame_end = busy && bit_tick && (idx == LAST_IDX);
    assign txd       = sh[0];

    // Load, shift or retire the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            state <= SH_IDLE;
            sh    <= '1;
            idx   <= '0;
        end else if (load) begin
            state <= SH_BUSY;
            sh    <= load_idle ? '1 : {1'b1, load_data, 1'b0};
            idx   <= '0;
        end else if (busy && bit_tick) begin
            if (idx == LAST_IDX) begin
                state <= SH_IDLE;
                sh    <= '1;
                idx   <= '0;
            end else begin
                sh  <= {1'b1, sh[F_W-1:1]};
                idx <= idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_tx_hold.sv
// Buffered serial transmitter top. It arbitrates what enters the shift
// register. An idle frame after enable comes first, then a held byte, then
// a write that bypasses the holding stage. It also keeps the completion
// flag and the interrupt request.
// Assumes wr_valid is a one-cycle strobe per byte.
module uart_tx_hold
    import uart_tx_pkg::*;
#(
    parameter int D_W = DATA_W,
    parameter int V_W = DIV_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tx_en,
    input  logic           irq_en,
    input  logic [V_W-1:0] divisor,
    input  logic           wr_valid,
    input  logic [D_W-1:0] wr_data,
    output logic           hold_empty,
    output logic           tx_done,
    output logic           irq,
    output logic           txd
);
    logic           en_q;
    logic           en_rise;
    logic           slot;
    logic           take_hold;
    logic           bypass;
    logic           load;
    logic           hold_full;
    logic [D_W-1:0] hold_data;
    logic           bit_tick;
    logic           busy;
    logic           frame_end;

    assign en_rise   = tx_en && !en_q;
    assign slot      = tx_en && (!busy || frame_end) && !en_rise;
    assign take_hold = slot && hold_full;
    assign bypass    = slot && !hold_full && wr_valid;
    assign load      = en_rise || take_hold || bypass;

    assign hold_empty = !hold_full;
    assign irq        = irq_en && !hold_full;

    // Remember the previous enable level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= tx_en;
    end

    // Completion flag: cleared by writes and loads, set when a frame retires.
    always_ff @(posedge clk) begin
        if (!rst_n)                tx_done <= 1'b1;
        else if (wr_valid || load) tx_done <= 1'b0;
        else if (frame_end)        tx_done <= 1'b1;
    end

    uart_baud_gen #(.DIV_W(V_W)) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load),
        .divisor (divisor),
        .tick    (bit_tick)
    );

    uart_hold_reg #(.DATA_W(D_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (wr_valid && !bypass),
        .wr_data (wr_data),
        .take    (take_hold),
        .full    (hold_full),
        .data    (hold_data)
    );

    uart_shifter #(.D_W(D_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (!tx_en),
        .bit_tick  (bit_tick),
        .load      (load),
        .load_idle (en_rise),
        .load_data (hold_full ? hold_data : wr_data),
        .busy      (busy),
        .frame_end (frame_end),
        .txd       (txd)
    );
endmodule

// File: rtl/uart_tx_hold_chk.sv
// Protocol checker for uart_tx_hold, attached by bind. It observes ports
// plus the shifter busy state and keeps its own copy of the enable history.
module uart_tx_hold_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic wr_valid,
    input logic hold_empty,
    input logic tx_done,
    input logic txd,
    input logic busy
);
    logic en_prev;

    // Track the enable level seen at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) en_prev <= 1'b0;
        else        en_prev <= tx_en;
    end

    AST_BYPASS_START: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && hold_empty && !busy && tx_en && en_prev |=> busy && hold_empty && !txd); // R3

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !hold_empty |=> !hold_empty); // R4

    AST_HOLD_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        !hold_empty && !busy && tx_en && en_prev && !wr_valid |=> hold_empty && busy); // R5

    AST_LINE_HIGH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> txd); // R7

    AST_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !tx_done); // R8
endmodule

bind uart_tx_hold uart_tx_hold_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .wr_valid   (wr_valid),
    .hold_empty (hold_empty),
    .tx_done    (tx_done),
    .txd        (txd),
    .busy       (u_shift.busy)
);

// File: tb/tb_uart_tx_hold.sv
// Directed bench for uart_tx_hold: one task per scenario, sampling on
// falling edges and driving inputs there too.
module tb_uart_tx_hold;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_en = 1'b0;
    logic        irq_en = 1'b1;
    logic [15:0] divisor = 16'd3;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        hold_empty, tx_done, irq, txd;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_tx_hold dut (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .irq_en(irq_en),
        .divisor(divisor), .wr_valid(wr_valid), .wr_data(wr_data),
        .hold_empty(hold_empty), .tx_done(tx_done), .irq(irq), .txd(txd)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Write one byte; returns at the falling edge after the accepting edge.
    task automatic write_byte(input logic [7:0] v);
        wr_valid = 1'b1;
        wr_data  = v;
        step(1);
        wr_valid = 1'b0;
    endtask

    // Checks a frame whose start bit occupies the current cycle (offset 0).
    // Returns at offset 10*(d+1), the first cycle after the stop bit.
    task automatic check_frame(input logic [7:0] v, input int d, input string req);
        int off = 0;
        for (int k = 0; k < 10; k++) begin
            int tgt = k * (d + 1) + d / 2;
            logic expb;
            step(tgt - off);
            off = tgt;
            expb = (k == 0) ? 1'b0 : (k == 9) ? 1'b1 : v[k-1];
            chk(req, $sformatf("frame %02h bit %0d", v, k), 32'(txd), 32'(expb));
        end
        step(10 * (d + 1) - off);
    endtask

    task automatic t_reset();
        chk("R1", "txd after reset", 32'(txd), 32'd1);
        chk("R1", "hold_empty after reset", 32'(hold_empty), 32'd1);
        chk("R1", "tx_done after reset", 32'(tx_done), 32'd1);
        chk("R9", "irq with enable set", 32'(irq), 32'd1);
        irq_en = 1'b0;
        step(1);
        chk("R9", "irq with enable clear", 32'(irq), 32'd0);
        irq_en = 1'b1;
    endtask

    // Writes while disabled, overwrite, then enable: idle frame then last byte.
    task automatic t_enable_idle();
        int highs = 0;
        write_byte(8'h3C);
        chk("R7", "held while disabled", 32'(hold_empty), 32'd0);
        chk("R9", "irq while held", 32'(irq), 32'd0);
        chk("R8", "done cleared by write", 32'(tx_done), 32'd0);
        step(30);
        chk("R7", "line high while disabled", 32'(txd), 32'd1);
        write_byte(8'h5A);
        tx_en = 1'b1;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (txd) highs++;
        end
        chk("R6", "idle frame high cycles", 32'(highs), 32'd40);
        step(1);
        chk("R6", "start bit right after idle frame", 32'(txd), 32'd0);
        chk("R5", "hold empty once taken", 32'(hold_empty), 32'd1);
        check_frame(8'h5A, 3, "R2");
        chk("R8", "done after last frame", 32'(tx_done), 32'd1);
        highs = 0;
        for (int i = 0; i < 60; i++) begin
            step(1);
            if (txd) highs++;
        end
        chk("R4", "overwritten byte not sent", 32'(highs), 32'd60);
    endtask

    task automatic t_bypass();
        write_byte(8'hA5);
        chk("R3", "start bit next cycle", 32'(txd), 32'd0);
        chk("R3", "hold stays empty", 32'(hold_empty), 32'd1);
        chk("R8", "done cleared", 32'(tx_done), 32'd0);
        check_frame(8'hA5, 3, "R3");
        chk("R8", "done set at frame end", 32'(tx_done), 32'd1);
        step(5);
    endtask

    task automatic t_back_to_back();
        write_byte(8'hC3);
        step(2);
        write_byte(8'h81);
        chk("R4", "held during frame", 32'(hold_empty), 32'd0);
        chk("R9", "irq low while held", 32'(irq), 32'd0);
        step(40 - 1 - 3);
        chk("R5", "stop bit last cycle", 32'(txd), 32'd1);
        chk("R5", "still held in stop bit", 32'(hold_empty), 32'd0);
        step(1);
        chk("R5", "no-gap start bit", 32'(txd), 32'd0);
        chk("R5", "hold emptied at handoff", 32'(hold_empty), 32'd1);
        chk("R9", "irq back high", 32'(irq), 32'd1);
        check_frame(8'h81, 3, "R5");
        chk("R8", "done after second frame", 32'(tx_done), 32'd1);
        step(5);
    endtask

    task automatic t_div_zero();
        divisor = 16'd0;
        step(2);
        write_byte(8'h96);
        check_frame(8'h96, 0, "R2");
        divisor = 16'd3;
        step(3);
    endtask

    task automatic t_abort();
        int highs = 0;
        write_byte(8'h00);
        step(5);
        chk("R7", "line low mid frame", 32'(txd), 32'd0);
        tx_en = 1'b0;
        step(1);
        chk("R7", "line high after disable", 32'(txd), 32'd1);
        for (int i = 0; i < 30; i++) begin
            step(1);
            if (txd) highs++;
        end
        chk("R7", "line stays high disabled", 32'(highs), 32'd30);
        tx_en = 1'b1;
        step(45);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_enable_idle();
        t_bypass();
        t_back_to_back();
        t_div_zero();
        t_abort();
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule